// File: doc/BRIEF.md
# I2C Master Word Transfer Engine

This block is the data phase of an I2C master. Software drives it through a small register interface. It has a data buffer, a 3-bit word-length field, an acknowledge-clock enable, a direction bit and a service flag. The engine clocks one word onto the bus, or off it, each time it is triggered. Between words it parks the bus by pulling SCL low, and it pulses an interrupt request. The bus moves again only when software touches the buffer. A write restarts a transmit sequence. A read restarts a receive sequence.

The first word, normally the slave address, is launched by a go bit written to the control register while the engine is idle. A master receiver ends a transfer in two steps. It turns off the acknowledge clock before reading the second-to-last word. It then reads once more with a one-bit length, which produces a single clock with SDA left high as the not-acknowledge. START and STOP conditions, arbitration and slave operation are handled elsewhere.

SCL and SDA are open-drain. The block drives only pull-low enables, and it samples the SDA wire. SCL is the system clock divided down, with high and low phases of `HALF_CYCLES` system clocks each.

Top module: `i2c_word_engine`

## Requirements
- R1: The word-length field is control bits [2:0], at address 1. The value 000 gives eight data clocks, and a value k from 1 to 7 gives exactly k data clocks.
- R2: Control bit 3 enables the acknowledge clock. When it is 1, one extra clock follows the data clocks. When it is 0, no extra clock is produced.
- R3: Data is sent most significant bit first. The master changes its SDA drive only while SCL is low, and SDA is sampled as SCL rises. Each SCL phase lasts `HALF_CYCLES` system clocks.
- R4: When a word completes, `irq` pulses for one cycle, and the service flag (status bit 6) falls to 0 in that same cycle. SCL then stays low, with no further clocks, until software services the engine.
- R5: Transmit mode is control bit 4 = 1. While the engine is stalled in this mode, a write to the buffer (address 0) restarts the clock and sends the written value. A buffer read in this mode restarts nothing.
- R6: Receive mode is control bit 4 = 0. While the engine is stalled in this mode, a buffer read returns the buffer, sets the service flag to 1 and starts the next word. A buffer write in this mode restarts nothing.
- R7: In receive mode the master leaves SDA released during data clocks and pulls it low during the acknowledge clock. The k received bits land in the low k bits of the buffer.
- R8: In transmit mode, the SDA level sampled on the acknowledge clock is held in status bit 7.
- R9: While idle, a buffer write only loads the buffer. A control write with bit 5 set starts the first word, using the buffer contents and the newly written settings.
- R10: After reset, SCL and SDA are released and `irq` is 0. The status register reads 0x58: length 000, acknowledge on, transmit, service flag 1, last bit 0.
- R11: In receive mode with the acknowledge clock off and length 001, a buffer read yields exactly one clock, and the master keeps SDA released during it (not-acknowledge).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 1 | 0 = data buffer, 1 = control/status |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | One-cycle end-of-word interrupt request |
| sclOutLow | output | 1 | Pull SCL low when 1 |
| sdaOutLow | output | 1 | Pull SDA low when 1 |
| sdaIn | input | 1 | Sampled SDA wire level |

## Verification
The bench sweeps every transmit and receive byte value, and every word length with the acknowledge clock both on and off. It counts SCL rises and records the SDA wire at each rise. Several failure modes are caught this way:
- An off-by-one in the clock count, or a bit order that is reversed, shows up as a wrong rise count or a scrambled capture.
- A buffer access that restarts the wrong direction shows up as unexpected rises while the engine should be parked.
- A receiver that fails to pull SDA low on the acknowledge clock shows up as a 1 in the captured acknowledge bit.
- A not-acknowledge step that emits more than one clock, or drives SDA low, breaks the two-step ending sequence.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  localparam int WORD_BITS = 8;
  localparam int CNT_W     = 3;
  localparam int IDX_W     = 4;

  // control register bit positions
  localparam int CTL_ACK_BIT = 3;
  localparam int CTL_TX_BIT  = 4;
  localparam int CTL_GO_BIT  = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_STALL
  } engState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWord;
    logic driveData;
    logic driveAck;
    logic sampleData;
    logic sampleAck;
    logic wordEnd;
    logic dirTx;
  } dpCtl_t;

endpackage

// File: rtl/i2cw_ctrl.sv
module i2cw_ctrl
  import i2cw_pkg::*;
#(
  parameter int HALF_CYCLES = 4   // system clocks per SCL phase, at least 2
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWr,
  input  logic             bufWr,
  input  logic             bufRd,
  input  logic [5:0]       ctrlData,
  output dpCtl_t           dpCtl,
  output logic             sclLow,
  output logic             irq,
  output logic             runFlag,
  output logic [CNT_W-1:0] cfgCount,
  output logic             cfgAck,
  output logic             cfgTx
);

  localparam int DIV_W = (HALF_CYCLES > 2) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYCLES - 1);

  engState_t        state;
  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] dataLen;
  logic [IDX_W-1:0] wordLen;
  logic             dirLatch;

  logic [CNT_W-1:0] nextCount;
  logic             nextAck;
  logic             nextTx;
  logic [IDX_W-1:0] startLen;
  logic             goReq;
  logic             resumeReq;
  logic             startWord;
  logic             phaseEnd;
  logic             inData;
  logic             lastClock;

  // settings that the word about to start will use
  assign nextCount = ctrlWr ? ctrlData[CNT_W-1:0] : cfgCount;
  assign nextAck   = ctrlWr ? ctrlData[CTL_ACK_BIT] : cfgAck;
  assign nextTx    = ctrlWr ? ctrlData[CTL_TX_BIT] : cfgTx;
  assign startLen  = (nextCount == '0) ? IDX_W'(WORD_BITS) : IDX_W'(nextCount);

  assign goReq     = (state == ST_IDLE) && ctrlWr && ctrlData[CTL_GO_BIT];
  assign resumeReq = (state == ST_STALL) && ((cfgTx && bufWr) || (!cfgTx && bufRd));
  assign startWord = goReq || resumeReq;
  assign phaseEnd  = (divCnt == DIV_LAST);
  assign inData    = (bitIdx < dataLen);
  assign lastClock = (bitIdx == wordLen - IDX_W'(1));

  // configuration register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgCount <= '0;
      cfgAck   <= 1'b1;
      cfgTx    <= 1'b1;
    end else if (ctrlWr) begin
      cfgCount <= ctrlData[CNT_W-1:0];
      cfgAck   <= ctrlData[CTL_ACK_BIT];
      cfgTx    <= ctrlData[CTL_TX_BIT];
    end
  end

  // bit sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      bitIdx   <= '0;
      dataLen  <= IDX_W'(WORD_BITS);
      wordLen  <= IDX_W'(WORD_BITS);
      dirLatch <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE, ST_STALL: begin
          if (startWord) begin
            state    <= ST_LOW;
            divCnt   <= '0;
            bitIdx   <= '0;
            dataLen  <= startLen;
            wordLen  <= startLen + IDX_W'(nextAck);
            dirLatch <= nextTx;
          end
        end
        ST_LOW: begin
          if (phaseEnd) begin
            state  <= ST_HIGH;
            divCnt <= '0;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_HIGH: begin
          if (phaseEnd) begin
            divCnt <= '0;
            if (lastClock) begin
              state <= ST_STALL;
            end else begin
              state  <= ST_LOW;
              bitIdx <= bitIdx + IDX_W'(1);
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // strobes to the datapath
  always_comb begin
    dpCtl            = '0;
    dpCtl.loadWord   = startWord;
    dpCtl.driveData  = (state == ST_LOW) && (divCnt == '0) && inData;
    dpCtl.driveAck   = (state == ST_LOW) && (divCnt == '0) && !inData;
    dpCtl.sampleData = (state == ST_LOW) && phaseEnd && inData;
    dpCtl.sampleAck  = (state == ST_LOW) && phaseEnd && !inData;
    dpCtl.wordEnd    = (state == ST_HIGH) && phaseEnd && lastClock;
    dpCtl.dirTx      = dirLatch;
  end

  assign sclLow = (state == ST_LOW) || (state == ST_STALL);

  // service flag and interrupt pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runFlag <= 1'b1;
      irq     <= 1'b0;
    end else begin
      irq <= dpCtl.wordEnd;
      if (dpCtl.wordEnd) begin
        runFlag <= 1'b0;
      end else if (startWord) begin
        runFlag <= 1'b1;
      end
    end
  end

  // R4: a pending service keeps SCL low
  assert_scl_parked_R4: assert property (@(posedge clk) disable iff (!rstN)
    !runFlag |-> sclLow);

  // R4: the flag drops together with the interrupt pulse
  assert_irq_with_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(runFlag) |-> irq);

  // R5: in transmit mode only a buffer write resumes the bus
  assert_tx_resume_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(runFlag) && $past(cfgTx)) |-> $past(bufWr));

  // R6: in receive mode only a buffer read resumes the bus
  assert_rx_resume_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(runFlag) && !$past(cfgTx)) |-> $past(bufRd));

  // R1: the clock index stays inside the word length, at most data plus acknowledge
  assert_clock_count_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOW || state == ST_HIGH) |->
      (bitIdx < wordLen && wordLen <= IDX_W'(WORD_BITS + 1)));

endmodule

// File: rtl/i2cw_datapath.sv
module i2cw_datapath
  import i2cw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               dpCtl,
  input  logic                 bufWr,
  input  logic [WORD_BITS-1:0] wdata,
  input  logic                 sdaIn,
  input  logic                 sclLow,
  output logic [WORD_BITS-1:0] dataBuf,
  output logic                 sdaLow,
  output logic                 lastBit
);

  logic [WORD_BITS-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataBuf  <= '0;
      shiftReg <= '0;
      sdaLow   <= 1'b0;
      lastBit  <= 1'b0;
    end else begin
      // buffer: received word wins over a simultaneous host write
      if (dpCtl.wordEnd && !dpCtl.dirTx) begin
        dataBuf <= shiftReg;
      end else if (bufWr) begin
        dataBuf <= wdata;
      end

      // shifter: the word loads at start, then one bit per SCL rise
      if (dpCtl.loadWord) begin
        shiftReg <= bufWr ? wdata : dataBuf;
      end else if (dpCtl.sampleData) begin
        shiftReg <= {shiftReg[WORD_BITS-2:0], sdaIn};
      end

      // SDA drive is updated one cycle into the low phase
      if (dpCtl.driveData) begin
        sdaLow <= dpCtl.dirTx & ~shiftReg[WORD_BITS-1];
      end else if (dpCtl.driveAck) begin
        sdaLow <= ~dpCtl.dirTx;
      end

      if (dpCtl.sampleAck && dpCtl.dirTx) begin
        lastBit <= sdaIn;
      end
    end
  end

  // R3: SDA drive moves only inside an SCL low phase
  assert_sda_in_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaLow) |-> ($past(sclLow) && sclLow));

  // R3: a sample strobe is always followed by the SCL rise
  assert_sample_at_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.sampleData || dpCtl.sampleAck) |=> !sclLow);

  // R7: a receiving master pulls SDA low for the acknowledge clock
  assert_rx_ack_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.driveAck && !dpCtl.dirTx) |=> sdaLow);

endmodule

// File: rtl/i2c_word_engine.sv
module i2c_word_engine
  import i2cw_pkg::*;
#(
  parameter int HALF_CYCLES = 4
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic       regRd,
  input  logic       regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       irq,
  output logic       sclOutLow,
  output logic       sdaOutLow,
  input  logic       sdaIn
);

  dpCtl_t           dpCtl;
  logic             bufWr;
  logic             bufRd;
  logic             ctrlWr;
  logic             runFlag;
  logic             lastBit;
  logic [CNT_W-1:0] cfgCount;
  logic             cfgAck;
  logic             cfgTx;
  logic [7:0]       dataBuf;

  assign bufWr  = regWr && !regAddr;
  assign bufRd  = regRd && !regAddr;
  assign ctrlWr = regWr && regAddr;

  i2cw_ctrl #(.HALF_CYCLES(HALF_CYCLES)) ctrlUnit (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWr   (ctrlWr),
    .bufWr    (bufWr),
    .bufRd    (bufRd),
    .ctrlData (regWdata[5:0]),
    .dpCtl    (dpCtl),
    .sclLow   (sclOutLow),
    .irq      (irq),
    .runFlag  (runFlag),
    .cfgCount (cfgCount),
    .cfgAck   (cfgAck),
    .cfgTx    (cfgTx)
  );

  i2cw_datapath dataUnit (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtl   (dpCtl),
    .bufWr   (bufWr),
    .wdata   (regWdata),
    .sdaIn   (sdaIn),
    .sclLow  (sclOutLow),
    .dataBuf (dataBuf),
    .sdaLow  (sdaOutLow),
    .lastBit (lastBit)
  );

  // status layout: [7] last ack bit, [6] service flag, [5] reads 0, [4] tx, [3] ack, [2:0] length
  assign regRdata = regAddr ? {lastBit, runFlag, 1'b0, cfgTx, cfgAck, cfgCount} : dataBuf;

endmodule

// File: tb/i2c_word_engine_test.sv
module i2c_word_engine_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] regWdata = 8'h00;
  wire  [7:0] regRdata;
  wire        irq;
  wire        sclOutLow;
  wire        sdaOutLow;

  int          checks = 0;
  int          failures = 0;
  int          riseCnt = 0;
  int          riseBase = 0;
  logic [31:0] captured = '0;
  logic [15:0] drvMask = '0;
  int          relIdx;
  logic        slaveLow;
  wire         sdaLine;

  assign relIdx   = riseCnt - riseBase;
  assign slaveLow = (relIdx >= 0 && relIdx < 16) ? drvMask[relIdx[3:0]] : 1'b0;
  assign sdaLine  = !(sdaOutLow || slaveLow);

  i2c_word_engine uut (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regRd    (regRd),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .irq      (irq),
    .sclOutLow(sclOutLow),
    .sdaOutLow(sdaOutLow),
    .sdaIn    (sdaLine)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // SCL rise: record the wire, then advance the slave's clock index
  always @(negedge sclOutLow) begin
    captured = {captured[30:0], sdaLine};
    riseCnt  = riseCnt + 1;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input bit addr, input logic [7:0] data);
    @(negedge clk);
    regAddr = addr; regWdata = data; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic busRead(input bit addr, output logic [7:0] data);
    @(negedge clk);
    regAddr = addr; regRd = 1'b1;
    #1 data = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic waitIrq(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
  endtask

  task automatic arm(input logic [15:0] mask);
    riseBase = riseCnt;
    drvMask  = mask;
  endtask

  function automatic int effLen(input int cnt);
    return (cnt == 0) ? 8 : cnt;
  endfunction

  // one transmit word; the engine must be stalled in transmit mode
  task automatic runTx(input int v, input int cnt, input int ack, input int slvAck);
    int nEff;
    bit seen;
    logic [7:0] st;
    nEff = effLen(cnt);
    arm((ack != 0 && slvAck != 0) ? (16'h1 << nEff) : 16'h0);
    busWrite(1'b0, v[7:0]);
    waitIrq(seen);
    check("R4", "irq after transmit word", int'(seen), 1);
    check("R1", "clock count (R2 ack clock)", riseCnt - riseBase, nEff + ack);
    check("R3", "msb-first data on wire",
          int'((captured >> ack) & ((32'h1 << nEff) - 1)), (v & 255) >> (8 - nEff));
    check("R4", "SCL held low after word", int'(sclOutLow), 1);
    busRead(1'b1, st);
    check("R4", "service flag cleared", int'(st[6]), 0);
    if (ack != 0) check("R8", "sampled acknowledge bit", int'(st[7]), (slvAck != 0) ? 0 : 1);
  endtask

  // one receive word; the engine must be stalled in receive mode
  task automatic runRx(input int v, input int cnt, input int ack);
    int nEff;
    int lowMask;
    bit seen;
    logic [7:0] st;
    logic [7:0] d;
    logic [15:0] m;
    nEff = effLen(cnt);
    lowMask = (1 << nEff) - 1;
    m = '0;
    for (int k = 0; k < nEff; k++) m[k] = ~v[nEff-1-k];
    arm(m);
    busRead(1'b0, d);
    busRead(1'b1, st);
    check("R6", "service flag set by read", int'(st[6]), 1);
    waitIrq(seen);
    check("R4", "irq after receive word", int'(seen), 1);
    check("R1", "receive clock count", riseCnt - riseBase, nEff + ack);
    check("R7", "master releases SDA for data",
          int'((captured >> ack) & lowMask), v & lowMask);
    if (ack != 0) check("R7", "master acknowledge low", int'(captured[0]), 0);
    // switch to transmit so the buffer can be read without a restart
    busWrite(1'b1, 8'(cnt | (ack << 3) | 8'h10));
    busRead(1'b0, d);
    check("R7", "received bits in buffer", int'(d) & lowMask, v & lowMask);
    check("R5", "transmit-mode read starts nothing", riseCnt - riseBase, nEff + ack);
    busWrite(1'b1, 8'(cnt | (ack << 3)));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL R4 watchdog expired: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] st;
    bit seen;
    int held;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10", "SCL released", int'(sclOutLow), 0);
    check("R10", "SDA released", int'(sdaOutLow), 0);
    check("R10", "irq low", int'(irq), 0);
    busRead(1'b1, st);
    check("R10", "status after reset", int'(st), 8'h58);

    // idle buffer write only loads
    arm(16'h0);
    busWrite(1'b0, 8'hA5);
    repeat (20) @(negedge clk);
    check("R9", "idle write starts nothing", riseCnt - riseBase, 0);

    // go bit launches the first word
    arm(16'h0100);
    busWrite(1'b1, 8'h38);
    waitIrq(seen);
    check("R9", "go word completes", int'(seen), 1);
    check("R9", "go word clocks", riseCnt - riseBase, 9);
    check("R9", "go word data", int'(captured[8:1]), 8'hA5);

    // every transmit byte, acknowledge on, slave ack alternating
    for (int v = 0; v < 256; v++) runTx(v, 0, 1, v & 1);

    // parked bus stays parked; a read in transmit mode is ignored
    held = riseCnt;
    repeat (40) @(negedge clk);
    check("R4", "no clocks while stalled", riseCnt - held, 0);
    check("R4", "SCL still low while stalled", int'(sclOutLow), 1);
    busRead(1'b0, st);
    repeat (40) @(negedge clk);
    check("R5", "transmit-mode read starts nothing", riseCnt - held, 0);
    busRead(1'b1, st);
    check("R5", "flag stays clear after ignored read", int'(st[6]), 0);

    // every length, with and without the acknowledge clock
    for (int cnt = 0; cnt < 8; cnt++) begin
      for (int ack = 0; ack < 2; ack++) begin
        busWrite(1'b1, 8'(cnt | (ack << 3) | 8'h10));
        runTx((8'h5B ^ (cnt * 37)) & 255, cnt, ack, 1);
      end
    end

    // receive mode: a buffer write must not restart the bus
    busWrite(1'b1, 8'h08);
    held = riseCnt;
    busWrite(1'b0, 8'h5A);
    repeat (40) @(negedge clk);
    check("R6", "receive-mode write starts nothing", riseCnt - held, 0);
    busRead(1'b1, st);
    check("R6", "flag stays clear after ignored write", int'(st[6]), 0);

    // every receive byte with acknowledge
    for (int v = 0; v < 256; v++) runRx(v, 0, 1);

    // short receive word
    busWrite(1'b1, 8'h0B);
    runRx(5, 3, 1);

    // ending sequence: last word without ack, then a one-clock not-acknowledge
    busWrite(1'b1, 8'h08);
    runRx(8'h3C, 0, 1);
    busWrite(1'b1, 8'h00);
    runRx(8'h96, 0, 0);
    busWrite(1'b1, 8'h01);
    runRx(1, 1, 0);
    check("R11", "single not-acknowledge clock", riseCnt - riseBase, 1);
    check("R11", "SDA high on not-acknowledge", int'(captured[0]), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule